// File: doc/BRIEF.md
# Board Configuration Switch Override Controller

This block sits in a board-control FPGA and gives software a byte-wide register window onto eight physical 8-bit configuration switches. Each switch has a software value register and an enable mask, and every bit of the configuration the board sees comes either from the physical switch or from the software value, picked one bit at a time by the mask. The merged configuration drives the board straight away, and two small decoders read clock selects and the boot-bank choice from it.

Software can ask for a board reset in two ways. A write to the hard-reset register asks for a reset that uses the plain physical switches. A 0-then-1 write sequence on the sequencer control bit asks for a reset that applies the merged, overridden configuration. When either request is taken, the chosen configuration is frozen on the outputs and held until the reset logic acknowledges the request, so the board samples a value that does not move.

Top module: `cso_switch_ovr`

## Requirements
- R1: After power-on reset every software value and enable register is 0x00, no reset request is pending, the override flag is 0, and the configuration outputs equal the physical switches.
- R2: Software value register of switch x (x = 1..8) is at byte offset 0x20 + 2(x-1) and its enable register at 0x21 + 2(x-1); both are read/write and read back what was written. Read data appears on the cycle after the address is presented.
- R3: For each bit, the configuration output equals the software value bit when the enable bit is 1 and the physical switch bit when it is 0. Switch x occupies output bits 8x-1 down to 8(x-1).
- R4: Any write to offset 0x04, whatever the data, raises the reset request with the override flag 0, and the held configuration equals the physical switches at the time of the write; offset 0x04 reads as 0x00.
- R5: Writing a value with bit 0 clear to offset 0x10 and later a value with bit 0 set raises the reset request with the override flag 1, and the held configuration equals the merged configuration at the time of the second write.
- R6: A write of bit 0 = 1 to offset 0x10 that is not preceded by a write of bit 0 = 0 (at power-on or after an earlier 1) raises no request.
- R7: While a request is pending the configuration outputs hold the captured value regardless of switch or register changes, further reset writes are ignored, and the request drops on the cycle after the acknowledge input is sampled high.
- R8: Offsets 0x00, 0x01 and 0x02 read the board ID, architecture version and FPGA version parameters, and writes to them have no effect.
- R9: Offset 0x07 is read/write: bits 2:0 drive the system-clock select, bits 5:3 the memory-clock select, and bits 7:6 read as 0.
- R10: Boot-bank field is configuration bits 7:4 of switch 7; a field value below 8 gives a virtual bank equal to its low two bits with the emulator flag 0, and a value of 8 or more sets the emulator flag.
- R11: Every offset not listed above reads 0x00 and writes to it change nothing.
- R12: Offset 0x10 reads back the last bit 0 written to it in bit 0, with bits 7:1 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_addr | input | AW (6) | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the address |
| phys_sw | input | 8·NUM_SW (64) | Physical switches, switch x at bits 8x-1:8(x-1) |
| eff_cfg | output | 8·NUM_SW (64) | Effective configuration to the board |
| board_rst_req | output | 1 | Board reset request, held until acknowledged |
| rst_use_ovr | output | 1 | 1 when the pending reset applies overrides |
| rst_ack | input | 1 | Acknowledge from reset pulse logic |
| sys_clk_sel | output | 3 | System-clock select |
| mem_clk_sel | output | 3 | Memory-clock select |
| boot_vbank | output | 2 | Virtual boot bank |
| boot_emu | output | 1 | Boot from external flash emulator |

## Verification
The hardest situation to reach is a pending reset in which the inputs keep moving: the physical switches change, the register values change, and more reset writes arrive, all before the acknowledge. The stimulus takes a reset with overrides active, then alters the switch pattern and issues both kinds of reset write while the request is held, checking the frozen outputs after each. The arming rule of the sequencer bit is reached by writing 1 first from power-on and again straight after a fired sequence, and the boot decoder is swept over all sixteen field values through the override path.

// File: rtl/cso_pkg.sv
package cso_pkg;
    localparam int BYTE_W     = 8;
    localparam int OFS_ID     = 'h00;
    localparam int OFS_ARCH   = 'h01;
    localparam int OFS_FPGA   = 'h02;
    localparam int OFS_HRST   = 'h04;
    localparam int OFS_SPEED  = 'h07;
    localparam int OFS_SEQ    = 'h10;
    localparam int OFS_SWBASE = 'h20;
    localparam int CLK_SEL_W  = 3;

    typedef struct packed {
        logic [BYTE_W-1:0]    rdata;
        logic [2*CLK_SEL_W-1:0] speed;
    } top_state_t;
endpackage

// File: rtl/cso_regfile.sv
module cso_regfile
    import cso_pkg::*;
#(
    parameter int NUM_SW = 8,
    parameter int AW     = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [BYTE_W-1:0]        wr_data,
    output logic [NUM_SW*BYTE_W-1:0] shadow_flat,
    output logic [NUM_SW*BYTE_W-1:0] enable_flat
);
    typedef struct packed {
        logic [NUM_SW-1:0][BYTE_W-1:0] sh;
        logic [NUM_SW-1:0][BYTE_W-1:0] en;
    } rf_state_t;

    rf_state_t rf_d, rf_q;
    logic [NUM_SW-1:0] hit_sh, hit_en;

    for (genvar g = 0; g < NUM_SW; g++) begin : g_dec
        assign hit_sh[g] = wr_en && (wr_addr == AW'(OFS_SWBASE + 2*g));
        assign hit_en[g] = wr_en && (wr_addr == AW'(OFS_SWBASE + 2*g + 1));
        assign shadow_flat[g*BYTE_W +: BYTE_W] = rf_q.sh[g];
        assign enable_flat[g*BYTE_W +: BYTE_W] = rf_q.en[g];
    end

    always_comb begin
        rf_d = rf_q;
        for (int i = 0; i < NUM_SW; i++) begin
            if (hit_sh[i]) rf_d.sh[i] = wr_data;
            if (hit_en[i]) rf_d.en[i] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end
endmodule

// File: rtl/cso_merge.sv
module cso_merge
    import cso_pkg::*;
#(
    parameter int NUM_SW = 8
) (
    input  logic [NUM_SW*BYTE_W-1:0] phys_flat,
    input  logic [NUM_SW*BYTE_W-1:0] shadow_flat,
    input  logic [NUM_SW*BYTE_W-1:0] enable_flat,
    output logic [NUM_SW*BYTE_W-1:0] live_flat
);
    for (genvar g = 0; g < NUM_SW; g++) begin : g_sw
        localparam int LO = g * BYTE_W;
        logic [BYTE_W-1:0] ph, sh, en;
        assign ph = phys_flat[LO +: BYTE_W];
        assign sh = shadow_flat[LO +: BYTE_W];
        assign en = enable_flat[LO +: BYTE_W];
        assign live_flat[LO +: BYTE_W] = (sh & en) | (ph & ~en);
    end
endmodule

// File: rtl/cso_rst_seq.sv
module cso_rst_seq
    import cso_pkg::*;
#(
    parameter int NUM_SW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hard_wr,
    input  logic                     seq_wr,
    input  logic                     seq_bit,
    input  logic [NUM_SW*BYTE_W-1:0] phys_flat,
    input  logic [NUM_SW*BYTE_W-1:0] live_flat,
    input  logic                     ack,
    output logic                     req,
    output logic                     use_ovr,
    output logic                     seq_ctl,
    output logic [NUM_SW*BYTE_W-1:0] cfg_out
);
    localparam int CW = NUM_SW * BYTE_W;

    typedef struct packed {
        logic          req;
        logic          use_ovr;
        logic          armed;
        logic          ctl;
        logic [CW-1:0] hold;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (seq_wr) begin
            s_d.ctl   = seq_bit;
            s_d.armed = !seq_bit;
        end
        if (s_q.req) begin
            if (ack) s_d.req = 1'b0;
        end else if (hard_wr) begin
            s_d.req     = 1'b1;
            s_d.use_ovr = 1'b0;
            s_d.hold    = phys_flat;
        end else if (seq_wr && seq_bit && s_q.armed) begin
            s_d.req     = 1'b1;
            s_d.use_ovr = 1'b1;
            s_d.hold    = live_flat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req     = s_q.req;
    assign use_ovr = s_q.use_ovr;
    assign seq_ctl = s_q.ctl;
    assign cfg_out = s_q.req ? s_q.hold : live_flat;
endmodule

// File: rtl/cso_switch_ovr.sv
module cso_switch_ovr
    import cso_pkg::*;
#(
    parameter int          NUM_SW   = 8,
    parameter int          AW       = 6,
    parameter int          BOOT_SW  = 7,
    parameter logic [7:0]  BOARD_ID = 8'h4A,
    parameter logic [7:0]  ARCH_VER = 8'h02,
    parameter logic [7:0]  FPGA_VER = 8'h13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [AW-1:0]            bus_addr,
    input  logic                     bus_we,
    input  logic [7:0]               bus_wdata,
    output logic [7:0]               bus_rdata,
    input  logic [NUM_SW*8-1:0]      phys_sw,
    output logic [NUM_SW*8-1:0]      eff_cfg,
    output logic                     board_rst_req,
    output logic                     rst_use_ovr,
    input  logic                     rst_ack,
    output logic [2:0]               sys_clk_sel,
    output logic [2:0]               mem_clk_sel,
    output logic [1:0]               boot_vbank,
    output logic                     boot_emu
);
    localparam int CW      = NUM_SW * BYTE_W;
    localparam int BOOT_HI = BOOT_SW * BYTE_W - 1;

    logic [CW-1:0] shadow_flat, enable_flat, live_flat;
    logic          hard_wr, seq_wr, seq_ctl;
    logic [3:0]    boot_field;
    top_state_t    t_d, t_q;

    assign hard_wr = bus_we && (bus_addr == AW'(OFS_HRST));
    assign seq_wr  = bus_we && (bus_addr == AW'(OFS_SEQ));

    cso_regfile #(.NUM_SW(NUM_SW), .AW(AW)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_we),
        .wr_addr     (bus_addr),
        .wr_data     (bus_wdata),
        .shadow_flat (shadow_flat),
        .enable_flat (enable_flat)
    );

    cso_merge #(.NUM_SW(NUM_SW)) merge_i (
        .phys_flat   (phys_sw),
        .shadow_flat (shadow_flat),
        .enable_flat (enable_flat),
        .live_flat   (live_flat)
    );

    cso_rst_seq #(.NUM_SW(NUM_SW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hard_wr   (hard_wr),
        .seq_wr    (seq_wr),
        .seq_bit   (bus_wdata[0]),
        .phys_flat (phys_sw),
        .live_flat (live_flat),
        .ack       (rst_ack),
        .req       (board_rst_req),
        .use_ovr   (rst_use_ovr),
        .seq_ctl   (seq_ctl),
        .cfg_out   (eff_cfg)
    );

    always_comb begin
        t_d       = t_q;
        t_d.rdata = '0;
        if (bus_we && bus_addr == AW'(OFS_SPEED))
            t_d.speed = bus_wdata[2*CLK_SEL_W-1:0];
        if      (bus_addr == AW'(OFS_ID))    t_d.rdata = BOARD_ID;
        else if (bus_addr == AW'(OFS_ARCH))  t_d.rdata = ARCH_VER;
        else if (bus_addr == AW'(OFS_FPGA))  t_d.rdata = FPGA_VER;
        else if (bus_addr == AW'(OFS_SPEED)) t_d.rdata = {2'b00, t_q.speed};
        else if (bus_addr == AW'(OFS_SEQ))   t_d.rdata = {7'd0, seq_ctl};
        for (int i = 0; i < NUM_SW; i++) begin
            if (bus_addr == AW'(OFS_SWBASE + 2*i))
                t_d.rdata = shadow_flat[i*BYTE_W +: BYTE_W];
            if (bus_addr == AW'(OFS_SWBASE + 2*i + 1))
                t_d.rdata = enable_flat[i*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bus_rdata   = t_q.rdata;
    assign sys_clk_sel = t_q.speed[CLK_SEL_W-1:0];
    assign mem_clk_sel = t_q.speed[2*CLK_SEL_W-1:CLK_SEL_W];
    assign boot_field  = eff_cfg[BOOT_HI -: 4];
    assign boot_emu    = boot_field[3];
    assign boot_vbank  = boot_field[1:0];
endmodule

// File: rtl/cso_checker.sv
module cso_checker #(
    parameter int         NUM_SW   = 8,
    parameter int         AW       = 6,
    parameter logic [7:0] BOARD_ID = 8'h4A
) (
    input logic                clk,
    input logic                rst_n,
    input logic [AW-1:0]       bus_addr,
    input logic                bus_we,
    input logic [7:0]          bus_rdata,
    input logic [NUM_SW*8-1:0] eff_cfg,
    input logic                board_rst_req,
    input logic                rst_use_ovr,
    input logic                rst_ack
);
    assert_hard_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == AW'(4) && !board_rst_req) |=> (board_rst_req && !rst_use_ovr));

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (board_rst_req && !rst_ack) |=> (board_rst_req && $stable(eff_cfg) && $stable(rst_use_ovr)));

    assert_ack_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (board_rst_req && rst_ack) |=> !board_rst_req);

    assert_id_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(0)) |=> (bus_rdata == BOARD_ID));

    assert_unused_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(3) || bus_addr == AW'(5)) |=> (bus_rdata == 8'h00));
endmodule

bind cso_switch_ovr cso_checker #(
    .NUM_SW(NUM_SW), .AW(AW), .BOARD_ID(BOARD_ID)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_rdata     (bus_rdata),
    .eff_cfg       (eff_cfg),
    .board_rst_req (board_rst_req),
    .rst_use_ovr   (rst_use_ovr),
    .rst_ack       (rst_ack)
);

// File: tb/cso_switch_ovr_tb_top.sv
`timescale 1ns/1ps
module cso_switch_ovr_tb_top;
    localparam int NSW = 8;
    localparam int CW  = NSW * 8;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [5:0]    bus_addr = '0;
    logic          bus_we = 0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [CW-1:0] phys_sw = '0;
    logic [CW-1:0] eff_cfg;
    logic          board_rst_req, rst_use_ovr;
    logic          rst_ack = 0;
    logic [2:0]    sys_clk_sel, mem_clk_sel;
    logic [1:0]    boot_vbank;
    logic          boot_emu;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_sh [NSW];
    logic [7:0] m_en [NSW];
    logic [5:0] m_speed = '0;
    logic       m_ctl = 0;

    always #2.5 clk = ~clk;

    cso_switch_ovr dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .phys_sw(phys_sw),
        .eff_cfg(eff_cfg), .board_rst_req(board_rst_req), .rst_use_ovr(rst_use_ovr),
        .rst_ack(rst_ack), .sys_clk_sel(sys_clk_sel), .mem_clk_sel(mem_clk_sel),
        .boot_vbank(boot_vbank), .boot_emu(boot_emu)
    );

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
        if (a >= 6'h20 && a < 6'h30) begin
            if (a[0]) m_en[(a - 6'h20) >> 1] = d;
            else      m_sh[(a - 6'h20) >> 1] = d;
        end
        if (a == 6'h07) m_speed = d[5:0];
        if (a == 6'h10) m_ctl = d[0];
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 0;
        @(negedge clk);
        d = bus_rdata;
    endtask

    function automatic logic [7:0] exp_rd(input logic [5:0] a);
        if (a == 6'h00) return 8'h4A;
        if (a == 6'h01) return 8'h02;
        if (a == 6'h02) return 8'h13;
        if (a == 6'h07) return {2'b00, m_speed};
        if (a == 6'h10) return {7'd0, m_ctl};
        if (a >= 6'h20 && a < 6'h30) return a[0] ? m_en[(a - 6'h20) >> 1] : m_sh[(a - 6'h20) >> 1];
        return 8'h00;
    endfunction

    function automatic logic [CW-1:0] merged(input logic [CW-1:0] ph);
        logic [CW-1:0] r;
        for (int i = 0; i < NSW; i++)
            r[i*8 +: 8] = (m_sh[i] & m_en[i]) | (ph[i*8 +: 8] & ~m_en[i]);
        return r;
    endfunction

    task automatic sweep_reads(input string tag);
        logic [7:0] d;
        for (int a = 0; a < 64; a++) begin
            rd(6'(a), d);
            chk(d == exp_rd(6'(a)), tag, {56'd0, d}, {56'd0, exp_rd(6'(a))});
        end
    endtask

    task automatic ack_req();
        @(negedge clk); rst_ack = 1;
        @(negedge clk); rst_ack = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [CW-1:0] snap;
        for (int i = 0; i < NSW; i++) begin m_sh[i] = 0; m_en[i] = 0; end
        phys_sw = 64'hC3A5_0F96_7E81_33CC;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(eff_cfg == phys_sw, "R1 eff=phys", eff_cfg, phys_sw);
        chk(!board_rst_req && !rst_use_ovr, "R1 no req", {62'd0, board_rst_req, rst_use_ovr}, 0);
        // R6 write 1 without prior 0
        wr(6'h10, 8'h01);
        chk(!board_rst_req, "R6 first 1 no fire", {63'd0, board_rst_req}, 0);
        sweep_reads("R1 R8 R11 R12 reset reads");
        // R2 program every switch pair, plus writes to read-only/unused offsets
        for (int i = 0; i < NSW; i++) begin
            wr(6'(32 + 2*i), 8'(8'h5A ^ (8'h11 * (i + 1))));
            wr(6'(33 + 2*i), 8'(8'h0F << (i % 5)) ^ 8'(i));
        end
        for (int a = 0; a < 32; a++)
            if (a != 4 && a != 7 && a != 16) wr(6'(a), 8'hA5);
        for (int a = 48; a < 64; a++) wr(6'(a), 8'hA5);
        chk(!board_rst_req, "R11 stray writes no req", {63'd0, board_rst_req}, 0);
        sweep_reads("R2 R8 R11 readback");
        // R3 merge over several physical patterns
        for (int p = 0; p < 6; p++) begin
            @(negedge clk);
            phys_sw = {8{8'(8'h37 * p + 8'h1D)}} ^ (64'hFF00_F0F0_CC33_5AA5 << p);
            #1;
            chk(eff_cfg == merged(phys_sw), "R3 merge", eff_cfg, merged(phys_sw));
        end
        // R9 speed register
        wr(6'h07, 8'hFF);
        chk(sys_clk_sel == 3'd7 && mem_clk_sel == 3'd7, "R9 sel all ones", {58'd0, mem_clk_sel, sys_clk_sel}, 64'h3F);
        wr(6'h07, 8'hEA);
        chk(sys_clk_sel == 3'd2 && mem_clk_sel == 3'd5, "R9 sel split", {58'd0, mem_clk_sel, sys_clk_sel}, 64'h2A);
        sweep_reads("R9 readback");
        // R10 boot field sweep via override of switch 7 upper nibble
        wr(6'h2D, 8'hF0);
        for (int f = 0; f < 16; f++) begin
            wr(6'h2C, 8'(f << 4) | 8'h09);
            chk(boot_emu == (f >= 8), "R10 emu", {63'd0, boot_emu}, {63'd0, f >= 8});
            if (f < 8) chk(boot_vbank == 2'(f), "R10 vbank", {62'd0, boot_vbank}, 64'(f & 3));
        end
        // R4 hard reset, then R7 hold while inputs move
        @(negedge clk); phys_sw = 64'h0123_4567_89AB_CDEF;
        snap = phys_sw;
        wr(6'h04, 8'h00);
        chk(board_rst_req && !rst_use_ovr, "R4 hard req", {62'd0, board_rst_req, rst_use_ovr}, 64'h2);
        chk(eff_cfg == snap, "R4 held=phys", eff_cfg, snap);
        phys_sw = 64'hFEDC_BA98_7654_3210;
        wr(6'h21, 8'hFF);
        wr(6'h04, 8'h55);
        wr(6'h10, 8'h00);
        wr(6'h10, 8'h01);
        chk(eff_cfg == snap, "R7 held stable", eff_cfg, snap);
        chk(!rst_use_ovr, "R7 extra writes ignored", {63'd0, rst_use_ovr}, 0);
        ack_req();
        chk(!board_rst_req, "R7 drop after ack", {63'd0, board_rst_req}, 0);
        chk(eff_cfg == merged(phys_sw), "R7 live after ack", eff_cfg, merged(phys_sw));
        // R6 repeated 1 after a consumed/last-1 state
        wr(6'h10, 8'h01);
        chk(!board_rst_req, "R6 repeat 1 no fire", {63'd0, board_rst_req}, 0);
        // R12 readback of control bit
        sweep_reads("R12 ctl=1 reads");
        wr(6'h10, 8'hFE);
        chk(!board_rst_req, "R5 zero write no fire", {63'd0, board_rst_req}, 0);
        sweep_reads("R12 ctl=0 reads");
        // R5 sequenced reset with overrides
        snap = merged(phys_sw);
        wr(6'h10, 8'h01);
        chk(board_rst_req && rst_use_ovr, "R5 seq req", {62'd0, board_rst_req, rst_use_ovr}, 64'h3);
        chk(eff_cfg == snap, "R5 held=merged", eff_cfg, snap);
        phys_sw = ~phys_sw;
        wr(6'h23, 8'hAA);
        chk(eff_cfg == snap, "R7 held under change", eff_cfg, snap);
        ack_req();
        chk(!board_rst_req, "R7 seq drop", {63'd0, board_rst_req}, 0);
        wr(6'h10, 8'h01);
        chk(!board_rst_req, "R6 no retrigger", {63'd0, board_rst_req}, 0);
        chk(eff_cfg == merged(phys_sw), "R3 live final", eff_cfg, merged(phys_sw));
        finish_run();
    end
endmodule